// File: doc/BRIEF.md
# Pin Controller with Edge-Triggered Interrupts

This block controls thirteen general-purpose pins through a byte-wide register port. Each pin has two registers of its own. The first sets the pin's pad controls: direction, drive type, pull resistor and output level. The second returns the pin's synchronized input level and selects which edges of that level raise an interrupt. The pad drivers and pull resistors themselves sit outside the block; it only presents their control bits as outputs.

Detected edges set bits in two interrupt status registers. Pins 0 to 6 form group 0 and pins 7 to 12 form group 1. A software handler reads a status register and clears the bits it has serviced by writing ones to them. Each group also has a mask register. Any status bit that is set and not masked drives the single interrupt request output. All pins come out of reset as inputs, and every interrupt starts out masked.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every pin control and edge-select field reads 0, both status registers read 0, the mask registers read 0x7F (group 0) and 0x3F (group 1), and pad_oe and irq are low.
- R2: Address p (0..12) is pin p's output control register. Bit 5 drives pad_oe[p] (1 = output), bit 4 drives pad_push_pull[p] (1 = push-pull, 0 = open-drain), bit 3 drives pull_en[p], bits 2:1 drive pull_sel[2p+1:2p] (0 strong down, 1 strong up, 2 weak down, 3 weak up), and bit 0 drives pad_out[p]. Bits 7:6 read back as zero.
- R3: Address 13+p is pin p's input control register. Bit 0 returns pad_in[p] after a two-flop synchronizer, and a write to bit 0 has no effect. Bits 2:1 read back the edge-select code. Bits 7:3 read as zero.
- R4: With edge-select code 0 (off), 1 (falling), 2 (rising) or 3 (both), a matching change of the synchronized level sets the pin's status bit on the clock edge after the change. This is the third rising clock edge after pad_in changes. It happens whether or not the pin is masked.
- R5: The status of pins 0..6 sits in bits 6:0 at address 26, and the status of pins 7..12 sits in bits 5:0 at address 27. Status bits that are not implemented read as zero.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an edge and a clearing write reach the same bit on the same clock edge, the bit stays set.
- R7: The masks for pins 0..6 sit in bits 6:0 at address 28, and the masks for pins 7..12 sit in bits 5:0 at address 29. A mask bit of 1 blocks the pin from irq, and 0 lets it through.
- R8: irq is a register. One clock edge after any status bit is both set and unmasked, it goes high. It stays high until no such bit remains.
- R9: Addresses 30 and 31 read as zero, and writes to them change nothing.
- R10: reg_rdata is registered. It shows the register selected by reg_addr on the clock edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pad_in | input | 13 | Asynchronous pin levels |
| pad_oe | output | 13 | Output enable per pin |
| pad_out | output | 13 | Driven level per pin |
| pad_push_pull | output | 13 | Drive type per pin (1 push-pull) |
| pull_en | output | 13 | Pull resistor enable per pin |
| pull_sel | output | 26 | Two-bit pull selection per pin |
| irq | output | 1 | Interrupt request |

## Verification
The case that needs care is a new edge and a write-1-to-clear landing on the same status bit in the same cycle. To provoke it, the bench first sets a pin's bit with an edge. It then changes that pin's input and times the clearing write so the write is captured on the exact clock edge where the synchronized change sets the bit again. The bit must still read as set afterwards, and a later clearing write with no edge must clear it. Every pin is swept through all four edge-select codes in both edge directions, and each result is checked against the code's rising and falling bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  // Pad control fields in register bit order, bit 5 down to bit 0
  typedef struct packed {
    logic       dir_out;
    logic       push_pull;
    logic       pull_on;
    logic [1:0] pull_kind;
    logic       level;
  } pad_ctl_t;

  localparam int PAD_CTL_W = $bits(pad_ctl_t);

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 13,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       lvl,
  input  logic [W-1:0][1:0]  mode,
  output logic [W-1:0]       hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    // mode bit 1 selects rising, mode bit 0 selects falling
    assign hit[i] = (mode[i][1] & ~prev_q[i] &  lvl[i]) |
                    (mode[i][0] &  prev_q[i] & ~lvl[i]);
  end

  // R4
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
    ((hit & ~(lvl ^ $past(lvl))) == '0));
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic         wr_stat,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] mask
);
  logic [W-1:0] clr;

  assign clr = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      mask <= '1;
    end else begin
      stat <= (stat & ~clr) | hit;
      if (wr_mask) mask <= wdata;
    end
  end

  // R4
  stat_source_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~$past(stat) & ~$past(hit)) == '0));

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat & $past(clr & ~hit)) == '0));

  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(hit) & ~stat) == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int NUM_PINS    = 13,
  parameter int GRP0_PINS   = 7,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_push_pull,
  output logic [NUM_PINS-1:0]   pull_en,
  output logic [2*NUM_PINS-1:0] pull_sel,
  output logic                  irq
);
  import gpio_pkg::*;

  localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;
  localparam int ICTL_BASE = NUM_PINS;
  localparam int STAT_BASE = 2 * NUM_PINS;
  localparam int MASK_BASE = STAT_BASE + 2;
  localparam int REG_COUNT = MASK_BASE + 2;

  // Register state
  pad_ctl_t                    pad_ctl_q [NUM_PINS];
  edge_mode_e                  emode_q   [NUM_PINS];
  logic [NUM_PINS-1:0]         lvl_sync;
  logic [NUM_PINS-1:0][1:0]    mode_vec;
  logic [NUM_PINS-1:0]         hit;
  logic [NUM_PINS-1:0]         stat_all;
  logic [NUM_PINS-1:0]         mask_all;
  logic [DATA_W-1:0]           rd_d;
  logic                        unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:PAD_CTL_W];

  // Input synchronizer and edge detection
  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(lvl_sync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
    assign mode_vec[p] = emode_q[p];
  end

  gpio_edge_det #(.W(NUM_PINS)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl_sync), .mode(mode_vec), .hit(hit)
  );

  // Per-pin control registers
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_ctl_q[p] <= '0;
        emode_q[p]   <= EDGE_OFF;
      end else if (reg_we) begin
        if (reg_addr == ADDR_W'(p))
          pad_ctl_q[p] <= pad_ctl_t'(reg_wdata[PAD_CTL_W-1:0]);
        if (reg_addr == ADDR_W'(ICTL_BASE + p))
          emode_q[p] <= edge_mode_e'(reg_wdata[2:1]);
      end
    end

    assign pad_oe[p]          = pad_ctl_q[p].dir_out;
    assign pad_push_pull[p]   = pad_ctl_q[p].push_pull;
    assign pull_en[p]         = pad_ctl_q[p].pull_on;
    assign pull_sel[2*p +: 2] = pad_ctl_q[p].pull_kind;
    assign pad_out[p]         = pad_ctl_q[p].level;
  end

  // Interrupt groups
  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam int LO = (g == 0) ? 0 : GRP0_PINS;
    localparam int GW = (g == 0) ? GRP0_PINS : GRP1_PINS;
    logic wr_stat, wr_mask;

    assign wr_stat = reg_we && (reg_addr == ADDR_W'(STAT_BASE + g));
    assign wr_mask = reg_we && (reg_addr == ADDR_W'(MASK_BASE + g));

    gpio_irq_group #(.W(GW)) u_grp (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[LO +: GW]),
      .wr_stat (wr_stat),
      .wr_mask (wr_mask),
      .wdata   (reg_wdata[GW-1:0]),
      .stat    (stat_all[LO +: GW]),
      .mask    (mask_all[LO +: GW])
    );
  end

  // Read multiplexer
  always_comb begin
    rd_d = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (reg_addr == ADDR_W'(p))
        rd_d[PAD_CTL_W-1:0] = pad_ctl_q[p];
      if (reg_addr == ADDR_W'(ICTL_BASE + p))
        rd_d[2:0] = {emode_q[p], lvl_sync[p]};
    end
    if (reg_addr == ADDR_W'(STAT_BASE))
      rd_d[GRP0_PINS-1:0] = stat_all[GRP0_PINS-1:0];
    if (reg_addr == ADDR_W'(STAT_BASE + 1))
      rd_d[GRP1_PINS-1:0] = stat_all[NUM_PINS-1:GRP0_PINS];
    if (reg_addr == ADDR_W'(MASK_BASE))
      rd_d[GRP0_PINS-1:0] = mask_all[GRP0_PINS-1:0];
    if (reg_addr == ADDR_W'(MASK_BASE + 1))
      rd_d[GRP1_PINS-1:0] = mask_all[NUM_PINS-1:GRP0_PINS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_d;
      irq       <= |(stat_all & ~mask_all);
    end
  end

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(stat_all & ~mask_all)));

  // R9
  reserved_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) >= ADDR_W'(REG_COUNT)) |-> (reg_rdata == '0));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!reg_we) |-> $stable(pad_oe));
endmodule

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
  localparam int N  = 13;
  localparam int G0 = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_oe, pad_out, pad_push_pull, pull_en;
  logic [2*N-1:0] pull_sel;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl u_gpio_edge_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_push_pull(pad_push_pull),
    .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(5'd26, 8'hFF);
    wr(5'd27, 8'hFF);
  endtask

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 26; a++) begin
      rd(5'(a), d);
      chk("R1 ctrl reg reset", d, 0);
    end
    rd(5'd26, d); chk("R1 status0 reset", d, 0);
    rd(5'd27, d); chk("R1 status1 reset", d, 0);
    rd(5'd28, d); chk("R1 mask0 reset", d, 8'h7F);
    rd(5'd29, d); chk("R1 mask1 reset", d, 8'h3F);
    chk("R1 pad_oe reset", pad_oe, 0);
    chk("R1 irq reset", irq, 0);

    // R9 reserved addresses
    wr(5'd30, 8'hFF); wr(5'd31, 8'h00);
    rd(5'd30, d); chk("R9 addr30 reads zero", d, 0);
    rd(5'd31, d); chk("R9 addr31 reads zero", d, 0);
    rd(5'd28, d); chk("R9 mask0 untouched", d, 8'h7F);
    rd(5'd0, d);  chk("R9 pin0 ctrl untouched", d, 0);

    // R2 output control sweep
    for (int p = 0; p < N; p++) begin
      logic [7:0] v;
      v = 8'((p * 37 + 11) ^ (p << 4));
      wr(5'(p), v);
      rd(5'(p), d);
      chk("R2 readback", d, v & 8'h3F);
      chk("R2 pad_oe",  pad_oe[p], v[5]);
      chk("R2 push_pull", pad_push_pull[p], v[4]);
      chk("R2 pull_en", pull_en[p], v[3]);
      chk("R2 pull_sel", pull_sel[2*p +: 2], v[2:1]);
      chk("R2 pad_out", pad_out[p], v[0]);
    end
    for (int p = 0; p < N; p++) wr(5'(p), 8'h00);
    chk("R2 pad_oe cleared", pad_oe, 0);

    // R3 input control field layout
    wr(5'd13, 8'hFF);
    rd(5'd13, d); chk("R3 ictl readback", d, 8'h06);
    wr(5'd13, 8'h00);

    // R4 R5 R3 sweep every pin and every edge code
    for (int p = 0; p < N; p++) begin
      for (int code = 0; code < 4; code++) begin
        int sa, so, bp;
        sa = (p < G0) ? 26 : 27;
        so = (p < G0) ? 27 : 26;
        bp = (p < G0) ? p : p - G0;
        wr(5'(13 + p), 8'(code << 1));
        clear_all();
        pad_in[p] = 1'b1;
        settle();
        rd(5'(sa), d); chk("R4 rise status", d, (code >> 1) << bp);
        rd(5'(so), d); chk("R5 other group quiet", d, 0);
        rd(5'(13 + p), d); chk("R3 level high", d, 8'((code << 1) | 1));
        clear_all();
        @(negedge clk); pad_in[p] = 1'b0;
        settle();
        rd(5'(sa), d); chk("R4 fall status", d, (code & 1) << bp);
        rd(5'(13 + p), d); chk("R3 level low", d, 8'(code << 1));
        clear_all();
        wr(5'(13 + p), 8'h00);
      end
    end

    // R5 unimplemented status bits
    wr(5'd19, 8'h06);
    pad_in[6] = 1'b1; settle();
    wr(5'd26, 8'h80);
    rd(5'd26, d); chk("R5 bit7 reads zero, bit6 kept", d, 8'h40);
    clear_all(); wr(5'd19, 8'h00); pad_in[6] = 1'b0; settle();

    // R6 write-0 keeps, same-cycle clear and edge
    wr(5'd16, 8'h06);
    pad_in[3] = 1'b1; settle();
    wr(5'd26, 8'h00);
    rd(5'd26, d); chk("R6 write zero keeps bit", d, 8'h08);
    @(negedge clk); pad_in[3] = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_addr = 5'd26; reg_wdata = 8'h08; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    rd(5'd26, d); chk("R6 edge wins over clear", d, 8'h08);
    wr(5'd26, 8'h08);
    rd(5'd26, d); chk("R6 clear alone", d, 8'h00);
    wr(5'd16, 8'h00);

    // R7 R8 masking and irq
    wr(5'd22, 8'h04);
    pad_in[9] = 1'b1; settle();
    rd(5'd27, d); chk("R7 status sets while masked", d, 8'h04);
    chk("R7 masked irq low", irq, 0);
    wr(5'd29, 8'h3B);
    @(negedge clk);
    chk("R8 irq after unmask", irq, 1);
    rd(5'd29, d); chk("R7 mask readback", d, 8'h3B);
    wr(5'd28, 8'h7E);
    wr(5'd13, 8'h04);
    pad_in[0] = 1'b1; settle();
    wr(5'd27, 8'h04);
    @(negedge clk);
    chk("R8 irq held by other bit", irq, 1);
    wr(5'd26, 8'h01);
    @(negedge clk);
    chk("R8 irq drops when cleared", irq, 0);
    wr(5'd29, 8'h3F);
    pad_in[9] = 1'b0; pad_in[0] = 1'b0; settle();
    chk("R8 irq stays low", irq, 0);

    // R10 read latency
    @(negedge clk); reg_addr = 5'd28;
    chk("R10 data not yet updated", reg_rdata, 8'h3F);
    @(negedge clk);
    chk("R10 data after one edge", reg_rdata, 8'h7E);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule